// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

The block is a system watchdog timer programmed through three byte-wide registers. A control byte sets the enable, chooses whether an expiry requests a reset or an interrupt, picks one of eight power-of-two timeout lengths, and turns on an optional first-stage transfer-acknowledge action. Software keeps the watchdog quiet by writing a two-byte key to a service register before the count runs out. A status byte records whether the last reset came from the hard reset pin or from the watchdog.

The control byte can be written once after each reset, so a running watchdog cannot be switched off by errant code. When the watchdog causes a reset, the block pulses its reset request, records the cause and returns to its post-reset programming state. An interrupt request stays up until software gives the full key. The timeouts can be shortened by a parameter so that a simulation can reach them.

Top module: `wdt_keyed`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `ctrl_o` reads 0x00, `status_o` reads 0x80 (bit 7 set: hard reset cause), and `rst_req_o`, `irq_o` and `xfer_ack_o` are low.
- R2: A control write (`wr_sel_i` = 0) loads bit 7 enable, bit 6 action select (1 reset, 0 interrupt), bits 5:3 timeout code and bit 2 acknowledge option only for the first write since reset; every later control write leaves these bits unchanged. Bit 0 reads 0.
- R3: Timeout code n (0..7) gives a period of 2^E cycles, E taken from 9, 11, 13, 15, 18, 20, 22, 24 in code order and lowered by `TO_SHIFT` (not below 0). Counting starts on the cycle after the enabling write or a restart, and the expiry output appears 2^E clock edges after that write.
- R4: On the service register (`wr_sel_i` = 1), a write of 0xAA restarts the count only when the preceding service write was 0x55; any other value written in between disarms the key.
- R5: In interrupt mode an expiry sets `irq_o`, which stays high until a full key restarts the count.
- R6: In reset mode an expiry gives a one-cycle `rst_req_o` pulse; in that cycle `status_o` reads 0x20 (bit 5: watchdog cause, bit 7 clear) and `ctrl_o` reads 0x00 with the control byte writable again.
- R7: With the acknowledge option on, an expiry while control bit 1 is clear gives a one-cycle `xfer_ack_o` pulse and sets bit 1 without raising the reset or interrupt; an expiry while bit 1 is set takes the selected action.
- R8: Writing a control byte with bit 1 set clears the acknowledge flag; with bit 1 clear the flag is unchanged.
- R9: Writes to the status register (`wr_sel_i` = 2) have no effect on `status_o`.
- R10: While the enable bit is clear the block never raises `rst_req_o`, `irq_o` or `xfer_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 service, 2 status |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control byte read value |
| status_o | output | 8 | Reset status byte read value |
| rst_req_o | output | 1 | One-cycle watchdog reset request |
| irq_o | output | 1 | Watchdog interrupt request, level |
| xfer_ack_o | output | 1 | One-cycle forced transfer acknowledge |

## Verification
The hardest state to reach is the two-stage expiry: a first timeout that only acknowledges and sets the flag, followed by a second timeout with the flag still set that fires the reset, all from a single write-once control value. The bench gets there by hard-resetting between scenarios so the control byte can be loaded afresh, using the shortest period so both expiries come in a few cycles, and comparing every output against a behavioural model on each clock. A cancelled key (0x55, another value, 0xAA) is applied while the interrupt is up so its lack of effect shows on `irq_o`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_SVC    = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } wdt_sel_e;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [7:0] STAT_HARD = 8'h80;
  localparam logic [7:0] STAT_WDOG = 8'h20;

  function automatic int unsigned wdt_exp(input logic [2:0] code);
    case (code)
      3'd0: return 9;
      3'd1: return 11;
      3'd2: return 13;
      3'd3: return 15;
      3'd4: return 18;
      3'd5: return 20;
      3'd6: return 22;
      default: return 24;
    endcase
  endfunction

  // terminal count (period - 1) after shortening
  function automatic int unsigned wdt_last(input logic [2:0] code, input int unsigned shift);
    int unsigned e;
    e = wdt_exp(code);
    e = (e > shift) ? e - shift : 0;
    return (32'd1 << e) - 32'd1;
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ta_set_i,
  output logic       en_o,
  output logic       rsel_o,
  output logic [2:0] tsel_o,
  output logic       ta_en_o,
  output logic       ta_flag_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      en_o     <= 1'b0;
      rsel_o   <= 1'b0;
      tsel_o   <= '0;
      ta_en_o  <= 1'b0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
      en_o     <= 1'b0;
      rsel_o   <= 1'b0;
      tsel_o   <= '0;
      ta_en_o  <= 1'b0;
    end else if (wr_i && !locked_q) begin
      locked_q <= 1'b1;
      en_o     <= wdata_i[7];
      rsel_o   <= wdata_i[6];
      tsel_o   <= wdata_i[5:3];
      ta_en_o  <= wdata_i[2];
    end
  end

  // set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ta_flag_o <= 1'b0;
    else if (clr_i)               ta_flag_o <= 1'b0;
    else if (ta_set_i)            ta_flag_o <= 1'b1;
    else if (wr_i && wdata_i[1])  ta_flag_o <= 1'b0;
  end
endmodule

// File: rtl/wdt_key.sv
module wdt_key (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       restart_o
);
  import wdt_pkg::*;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (clr_i) armed_q <= 1'b0;
    else if (wr_i)  armed_q <= (wdata_i == KEY_ARM);
  end

  assign restart_o = wr_i && armed_q && (wdata_i == KEY_FIRE);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !en_i)   cnt_q <= '0;
    else if (expire_o)         cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int unsigned TO_SHIFT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  output logic       rst_req_o,
  output logic       irq_o,
  output logic       xfer_ack_o
);
  import wdt_pkg::*;

  localparam int unsigned CNT_W = (TO_SHIFT < 24) ? 24 - TO_SHIFT : 1;

  logic en, rsel, ta_en, ta_flag;
  logic [2:0] tsel;
  logic restart, expire, take, ta_first, fire_rst, fire_irq;
  logic [CNT_W-1:0] last;
  logic wr_ctrl, wr_svc;

  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_svc  = wr_en_i && (wr_sel_i == SEL_SVC);
  assign last    = CNT_W'(wdt_last(tsel, TO_SHIFT));

  assign take     = expire && (!ta_en || ta_flag);
  assign ta_first = expire && ta_en && !ta_flag;
  assign fire_rst = take && rsel;
  assign fire_irq = take && !rsel;

  wdt_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .clr_i    (fire_rst),
    .wr_i     (wr_ctrl),
    .wdata_i  (wr_data_i),
    .ta_set_i (ta_first),
    .en_o     (en),
    .rsel_o   (rsel),
    .tsel_o   (tsel),
    .ta_en_o  (ta_en),
    .ta_flag_o(ta_flag)
  );

  wdt_key u_key (
    .clk_i, .rst_ni,
    .clr_i    (fire_rst),
    .wr_i     (wr_svc),
    .wdata_i  (wr_data_i),
    .restart_o(restart)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i    (en),
    .clr_i   (restart || fire_rst),
    .last_i  (last),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o  <= 1'b0;
      xfer_ack_o <= 1'b0;
      irq_o      <= 1'b0;
      status_o   <= STAT_HARD;
    end else begin
      rst_req_o  <= fire_rst;
      xfer_ack_o <= ta_first;
      if (fire_rst)      irq_o <= 1'b0;
      else if (restart)  irq_o <= 1'b0;
      else if (fire_irq) irq_o <= 1'b1;
      if (fire_rst) status_o <= STAT_WDOG;
    end
  end

  assign ctrl_o = {en, rsel, tsel, ta_en, ta_flag, 1'b0};
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] ctrl_o,
  input logic [7:0] status_o,
  input logic       rst_req_o,
  input logic       irq_o,
  input logic       xfer_ack_o
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (status_o == 8'h20) && (ctrl_o == 8'h00) && !irq_o); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |=> !xfer_ack_o); // R7
  AST_ACK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |-> ctrl_o[1] && !rst_req_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> rst_req_o || $past(wr_en_i && wr_sel_i == 2'd1 && wr_data_i == 8'hAA)); // R5
  AST_STATUS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o |-> $stable(status_o)); // R9
  AST_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0]); // R2
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[7] && !$past(ctrl_o[7])) |-> !xfer_ack_o && !rst_req_o); // R10
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (.*);

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  localparam int unsigned SHIFT = 8;
  localparam int EXPS[8] = '{9, 11, 13, 15, 18, 20, 22, 24};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] ctrl_o, status_o;
  logic rst_req_o, irq_o, xfer_ack_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_keyed #(.TO_SHIFT(SHIFT)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ctrl_o, .status_o, .rst_req_o, .irq_o, .xfer_ack_o
  );

  // reference model state
  bit m_en, m_rsel, m_ta, m_flag, m_lock, m_armed, m_irq, m_rst, m_ack;
  int m_tsel, m_cnt;
  logic [7:0] m_status;

  function automatic int period(input int code);
    int e = EXPS[code] - int'(SHIFT);
    if (e < 0) e = 0;
    return 1 << e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_rsel = 0; m_ta = 0; m_flag = 0; m_lock = 0; m_armed = 0;
    m_irq = 0; m_rst = 0; m_ack = 0; m_tsel = 0; m_cnt = 0; m_status = 8'h80;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      bit expire, restart, take, first, frst, wc, ws;
      cyc++;
      wc = wr_en_i && wr_sel_i == 2'd0;
      ws = wr_en_i && wr_sel_i == 2'd1;
      expire  = m_en && (m_cnt == period(m_tsel) - 1);
      restart = ws && wr_data_i == 8'hAA && m_armed;
      take    = expire && (!m_ta || m_flag);
      first   = expire && m_ta && !m_flag;
      frst    = take && m_rsel;
      m_rst = frst;
      m_ack = first;
      if (frst) begin
        m_en = 0; m_rsel = 0; m_ta = 0; m_flag = 0; m_lock = 0; m_tsel = 0;
        m_armed = 0; m_cnt = 0; m_irq = 0; m_status = 8'h20;
      end else begin
        if (restart || !m_en || expire) m_cnt = 0; else m_cnt++;
        if (ws) m_armed = (wr_data_i == 8'h55);
        if (restart) m_irq = 0; else if (take) m_irq = 1;
        if (first) m_flag = 1; else if (wc && wr_data_i[1]) m_flag = 0;
        if (wc && !m_lock) begin
          m_lock = 1; m_en = wr_data_i[7]; m_rsel = wr_data_i[6];
          m_tsel = int'(wr_data_i[5:3]); m_ta = wr_data_i[2];
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_ni && !done) begin
    logic [7:0] mc;
    mc = {m_en, m_rsel, 3'(m_tsel), m_ta, m_flag, 1'b0};
    check(ctrl_o == mc, "R2 ctrl_o", ctrl_o, mc);
    check(status_o == m_status, "R9 status_o", status_o, m_status);
    check(rst_req_o == m_rst, "R6 rst_req_o", rst_req_o, m_rst);
    check(irq_o == m_irq, "R5 irq_o", irq_o, m_irq);
    check(xfer_ack_o == m_ack, "R7 xfer_ack_o", xfer_ack_o, m_ack);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick(1);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic hard_reset();
    rst_ni = 1'b0;
    #3;
    check(ctrl_o == 8'h00 && status_o == 8'h80 && !rst_req_o && !irq_o && !xfer_ack_o,
          "R1 reset state", {ctrl_o, status_o}, 16'h0080);
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    check(ctrl_o == 8'h00 && status_o == 8'h80, "R1 after release", {ctrl_o, status_o}, 16'h0080);
  endtask

  task automatic wait_sig(input int which, output int n);
    n = 0;
    forever begin
      @(posedge clk); #2; n++;
      if (which == 0 && irq_o) break;
      if (which == 1 && rst_req_o) break;
      if (which == 2 && xfer_ack_o) break;
      if (n > 20000) break;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    tick(1);
    hard_reset();

    // R9: status writes ignored
    wr(2'd2, 8'h00);
    tick(1);
    check(status_o == 8'h80, "R9 status write ignored", status_o, 8'h80);

    // R3/R5: interrupt mode, code 2
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'h90;
    @(posedge clk); #2; wr_en_i = 1'b0;
    wait_sig(0, n);
    check(n == period(2), "R3 timeout length code2", n, period(2));

    // R2: second control write ignored
    wr(2'd0, 8'h00);
    check(ctrl_o == 8'h90, "R2 write-once", ctrl_o, 8'h90);

    // R4: broken key keeps the interrupt
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA);
    tick(1);
    check(irq_o == 1'b1, "R4 cancelled key no restart", irq_o, 1);
    wr(2'd1, 8'hAA);
    check(irq_o == 1'b1, "R4 lone AA no restart", irq_o, 1);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    check(irq_o == 1'b0, "R5 full key clears irq", irq_o, 0);

    // R4: regular servicing prevents expiry
    for (int k = 0; k < 6; k++) begin
      tick(20);
      wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
      check(irq_o == 1'b0, "R4 serviced no expiry", irq_o, 0);
    end

    // R6/R7: reset mode with acknowledge stage, code 0
    hard_reset();
    wr(2'd0, 8'hC4);
    wait_sig(2, n);
    check(ctrl_o[1] == 1'b1 && !rst_req_o, "R7 first expiry ack+flag", ctrl_o, 8'hC6);
    wait_sig(1, n);
    check(n == period(0), "R7 second expiry fires", n, period(0));
    check(status_o == 8'h20, "R6 status watchdog cause", status_o, 8'h20);
    check(ctrl_o == 8'h00, "R6 control cleared", ctrl_o, 8'h00);
    tick(1);
    wr(2'd0, 8'h98);
    check(ctrl_o == 8'h98, "R6 control writable again", ctrl_o, 8'h98);

    // R8: flag write-one-to-clear, code 1 with ack
    hard_reset();
    wr(2'd0, 8'h8C);
    wait_sig(2, n);
    check(n == period(1), "R3 timeout length code1", n, period(1));
    wr(2'd0, 8'h00);
    check(ctrl_o[1] == 1'b1, "R8 write 0 keeps flag", ctrl_o, 8'h8E);
    wr(2'd0, 8'h02);
    check(ctrl_o == 8'h8C, "R8 write 1 clears flag", ctrl_o, 8'h8C);

    // R10: disabled block stays quiet
    hard_reset();
    wr(2'd0, 8'h40);
    for (int k = 0; k < 40; k++) begin
      tick(1);
      check(!rst_req_o && !irq_o && !xfer_ack_o, "R10 disabled quiet",
            {rst_req_o, irq_o, xfer_ack_o}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule